// File: doc/BRIEF.md
# Die-to-Die Lane Self-Test Sequencer

This block runs the built-in self-test of a parallel die-to-die lane bundle made of data lanes plus spare lanes. A run selects one of four loopback paths, drives a fixed sequence of per-lane stimulus phases onto the transmit side, and checks each lane's received bits against the expected pattern. The expected pattern is delayed to match a programmable loopback latency, and only the lanes chosen for evaluation are checked. Each failing lane raises a sticky flag for the rest of the run.

Fail flags are OR-merged into a cumulative lane signature that persists across runs. Several runs, for instance one per supply or temperature corner, can be merged before any repair is committed. On a committing run the signature goes out over a valid/ready write port to the lane repair register. The sequencer then reruns the whole pattern set over the lanes actually in service after the remap, and reports the outcome of that rerun. At power-on a previously stored signature can be loaded first, so that known-bad lanes are neither tested nor counted.

Both data streams at the block edge use valid/ready. On the repair write port the block raises `rep_valid` and then holds `rep_valid` and `rep_data` unchanged until a cycle with `rep_ready` high completes the transfer. On the signature load port `sig_ready` is high only while the sequencer is idle and no start is being requested, and a transfer happens in any cycle where both `sig_valid` and `sig_ready` are high. Pattern and received lanes carry no handshake because they are raw physical lanes.

Top module: `d2d_lane_bist`

## Requirements
- R1: On an accepted start, `lb_sel` takes `cfg_mode` and keeps it until the run ends. The encoding is 0 internal, 1 near-end, 2 far-end, and 3 die-to-die (both chiplets' transmitter and receiver).
- R2: A run emits four phases of `cfg_phase_len` cycles each, with a length of 0 treated as 1, in this order. Walking-one: lane i is 1 when i equals t mod NL, where t is the cycle within the phase. Walking-zero: the inverse of walking-one. Alternating: lane i equals bit0 of i XOR bit0 of t. PRBS7: per lane, polynomial x^7+x^6+1, seed i+1, output taken from the MSB, advanced each cycle. `tx_pat` is all zero whenever no phase is being emitted.
- R3: Received data is compared against the emitted pattern delayed by `cfg_lat` cycles (0 to MAX_LAT), so a loopback with exactly that delay produces no fail.
- R4: A lane stuck at 0 or at 1, and both lanes of a shorted adjacent pair (wired-AND), are flagged as failing.
- R5: With `cfg_spares` = 0, mismatches on spare lanes (indices LANES and above) are ignored in the first run. With `cfg_spares` = 1 they are checked.
- R6: `done` is a one-cycle pulse at the end of a test, and `result` holds its outcome. The values are 2 (unrepairable) if the cumulative signature has more than SPARES bits set, otherwise 0 (pass) if no evaluated lane failed in the final run, otherwise 1 (repairable).
- R7: Each run ORs its failing lanes into the cumulative signature. A run with `cfg_accum` = 1 never writes the repair register.
- R8: A run with `cfg_accum` = 0 whose cumulative signature is nonzero and has at most SPARES bits set makes exactly one write of that signature (bit i = physical lane i) and holds it under back-pressure.
- R9: After that write is accepted, the pattern set runs again. It evaluates only the lanes in service, meaning the first LANES lanes in index order not marked in the signature, and its failures decide `result`.
- R10: A signature loaded while idle replaces the cumulative signature, and its lanes are excluded from evaluation. `sig_ready` is low while a test is in progress.
- R11: After reset, `busy`, `done`, `rep_valid` and `tx_pat` are zero, and `sig_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start request, taken while idle |
| cfg_mode | input | 2 | Loopback path for the run |
| cfg_spares | input | 1 | Also evaluate spare lanes in the first run |
| cfg_accum | input | 1 | Merge only, no repair write |
| cfg_phase_len | input | CNT_W | Cycles per pattern phase |
| cfg_lat | input | LAT_W | Loopback latency in cycles |
| lb_sel | output | 2 | Loopback path select to the PHY |
| tx_pat | output | LANES+SPARES | Per-lane transmit pattern |
| rx_dat | input | LANES+SPARES | Per-lane received data |
| rep_valid | output | 1 | Repair write valid |
| rep_ready | input | 1 | Repair register accepts |
| rep_data | output | LANES+SPARES | Lane signature to write |
| sig_valid | input | 1 | Stored signature offered |
| sig_ready | output | 1 | Signature can be taken |
| sig_data | input | LANES+SPARES | Stored signature |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle end-of-test pulse |
| result | output | 2 | Outcome of the last test |

## Verification
The bench covers every loopback latency from 0 to the maximum. A design whose history tap is off by one would flag almost every lane even on a clean link. It places a defect on a spare lane that only the post-repair rerun brings into service, so a design that skips the rerun or evaluates the wrong lane set would report pass where repairable is expected. It preloads known-bad lanes and then adds new faults, so that an exclusion that fails would raise false fails and a miscount would set the unrepairable boundary at the wrong number of lanes. A repair write is held back by a stalled ready, and a design that drops or changes the signature during the stall is caught, as is one that writes during merge-only runs.

// File: rtl/d2d_bist_pkg.sv
package d2d_bist_pkg;

  typedef enum logic [1:0] {
    RES_PASS         = 2'b00,
    RES_REPAIRABLE   = 2'b01,
    RES_UNREPAIRABLE = 2'b10
  } res_e;

  typedef enum logic [1:0] {
    PH_WALK1 = 2'd0,
    PH_WALK0 = 2'd1,
    PH_ALT   = 2'd2,
    PH_PRBS  = 2'd3
  } phase_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RUN   = 3'd1,
    ST_EVAL  = 3'd2,
    ST_WRITE = 3'd3,
    ST_DONE  = 3'd4
  } st_e;

  // x^7 + x^6 + 1, shifting toward the MSB
  function automatic logic [6:0] prbs7_next(input logic [6:0] s);
    return {s[5:0], s[6] ^ s[5]};
  endfunction

endpackage

// File: rtl/d2d_bist_patgen.sv
module d2d_bist_patgen
  import d2d_bist_pkg::*;
#(
  parameter int NL    = 10,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] phase_len,
  output logic [NL-1:0]    pat,
  output logic             active
);
  localparam int IDX_W = (NL > 1) ? $clog2(NL) : 1;

  phase_e           phase;
  logic [CNT_W-1:0] pcnt;
  logic [IDX_W-1:0] widx;
  logic [CNT_W-1:0] last_cnt;
  logic             end_phase;
  logic             reseed;
  logic             step;

  assign last_cnt  = (phase_len == '0) ? '0 : phase_len - 1'b1;
  assign end_phase = (pcnt == last_cnt);
  assign reseed    = restart | (active & end_phase);
  assign step      = active & ~end_phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      phase  <= PH_WALK1;
      pcnt   <= '0;
      widx   <= '0;
    end else if (restart) begin
      active <= 1'b1;
      phase  <= PH_WALK1;
      pcnt   <= '0;
      widx   <= '0;
    end else if (active) begin
      if (end_phase) begin
        pcnt <= '0;
        widx <= '0;
        if (phase == PH_PRBS) active <= 1'b0;
        else                  phase  <= phase_e'(phase + 2'd1);
      end else begin
        pcnt <= pcnt + 1'b1;
        widx <= (widx == IDX_W'(NL - 1)) ? '0 : widx + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NL; i++) begin : g_lane
    localparam logic [6:0] SEED = 7'(i + 1);
    localparam logic       ODD  = 1'((i % 2) == 1);
    logic [6:0] lfsr;
    logic       bit_v;

    always_ff @(posedge clk) begin
      if (!rst_n)      lfsr <= SEED;
      else if (reseed) lfsr <= SEED;
      else if (step)   lfsr <= prbs7_next(lfsr);
    end

    always_comb begin
      unique case (phase)
        PH_WALK1: bit_v = (widx == IDX_W'(i));
        PH_WALK0: bit_v = (widx != IDX_W'(i));
        PH_ALT:   bit_v = ODD ^ pcnt[0];
        default:  bit_v = lfsr[6];
      endcase
    end

    assign pat[i] = active & bit_v;
  end

endmodule

// File: rtl/d2d_bist_cmp.sv
module d2d_bist_cmp #(
  parameter int NL      = 10,
  parameter int MAX_LAT = 7,
  parameter int LAT_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [NL-1:0]    tx_now,
  input  logic             tx_act,
  input  logic [NL-1:0]    rx,
  input  logic [LAT_W-1:0] lat,
  input  logic [NL-1:0]    eval_mask,
  output logic [NL-1:0]    fail_q
);
  // entry = {valid, pattern}; hist[k] is the pattern from k+1 cycles ago
  logic [NL:0]      hist [MAX_LAT];
  logic [NL:0]      cur;
  logic [NL:0]      sel;
  logic [LAT_W-1:0] lat_c;

  assign cur   = {tx_act, tx_now};
  assign lat_c = (int'(lat) > MAX_LAT) ? LAT_W'(MAX_LAT) : lat;

  for (genvar k = 0; k < MAX_LAT; k++) begin : g_hist
    always_ff @(posedge clk) begin
      if (!rst_n || clear) hist[k] <= '0;
      else if (k == 0)     hist[k] <= cur;
      else                 hist[k] <= hist[(k == 0) ? 0 : k - 1];
    end
  end

  always_comb begin
    sel = cur;
    for (int k = 1; k <= MAX_LAT; k++)
      if (int'(lat_c) == k) sel = hist[k-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) fail_q <= '0;
    else if (sel[NL])    fail_q <= fail_q | ((sel[NL-1:0] ^ rx) & eval_mask);
  end

endmodule

// File: rtl/d2d_bist_inuse.sv
module d2d_bist_inuse #(
  parameter int NL    = 10,
  parameter int LANES = 8
) (
  input  logic [NL-1:0] bad,
  output logic [NL-1:0] inuse
);
  always_comb begin
    int taken;
    taken = 0;
    inuse = '0;
    for (int i = 0; i < NL; i++) begin
      if (!bad[i] && taken < LANES) begin
        inuse[i] = 1'b1;
        taken    = taken + 1;
      end
    end
  end
endmodule

// File: rtl/d2d_lane_bist.sv
module d2d_lane_bist
  import d2d_bist_pkg::*;
#(
  parameter  int LANES   = 8,
  parameter  int SPARES  = 2,
  parameter  int CNT_W   = 16,
  parameter  int MAX_LAT = 7,
  localparam int NL      = LANES + SPARES,
  localparam int LAT_W   = $clog2(MAX_LAT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_spares,
  input  logic             cfg_accum,
  input  logic [CNT_W-1:0] cfg_phase_len,
  input  logic [LAT_W-1:0] cfg_lat,
  output logic [1:0]       lb_sel,
  output logic [NL-1:0]    tx_pat,
  input  logic [NL-1:0]    rx_dat,
  output logic             rep_valid,
  input  logic             rep_ready,
  output logic [NL-1:0]    rep_data,
  input  logic             sig_valid,
  output logic             sig_ready,
  input  logic [NL-1:0]    sig_data,
  output logic             busy,
  output logic             done,
  output logic [1:0]       result
);
  localparam logic [NL-1:0] DATA_MASK = {{SPARES{1'b0}}, {LANES{1'b1}}};

  st_e              state;
  logic [1:0]       lb_q;
  logic             acc_q;
  logic             ver_q;
  logic [CNT_W-1:0] len_q;
  logic [LAT_W-1:0] lat_q;
  logic [LAT_W-1:0] dcnt;
  logic [NL-1:0]    eval_q;
  logic [NL-1:0]    sig_q;
  res_e             res_q;

  logic             start_ok;
  logic             wr_ok;
  logic             restart;
  logic             pg_act;
  logic [NL-1:0]    pg_pat;
  logic [NL-1:0]    fail_vec;
  logic [NL-1:0]    inuse;
  logic [NL-1:0]    scope;
  logic [NL-1:0]    sig_next;
  logic             too_many;
  logic             want_wr;

  assign start_ok = (state == ST_IDLE) && start;
  assign wr_ok    = (state == ST_WRITE) && rep_ready;
  assign restart  = start_ok | wr_ok;
  assign scope    = cfg_spares ? '1 : DATA_MASK;
  assign sig_next = sig_q | fail_vec;
  assign too_many = ($countones(sig_next) > SPARES);
  assign want_wr  = !acc_q && !ver_q && (sig_next != '0) && !too_many;

  d2d_bist_patgen #(.NL(NL), .CNT_W(CNT_W)) u_pat (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .phase_len (len_q),
    .pat       (pg_pat),
    .active    (pg_act)
  );

  d2d_bist_cmp #(.NL(NL), .MAX_LAT(MAX_LAT), .LAT_W(LAT_W)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (restart),
    .tx_now    (pg_pat),
    .tx_act    (pg_act),
    .rx        (rx_dat),
    .lat       (lat_q),
    .eval_mask (eval_q),
    .fail_q    (fail_vec)
  );

  d2d_bist_inuse #(.NL(NL), .LANES(LANES)) u_inuse (
    .bad   (sig_q),
    .inuse (inuse)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      lb_q   <= 2'd0;
      acc_q  <= 1'b0;
      ver_q  <= 1'b0;
      len_q  <= '0;
      lat_q  <= '0;
      dcnt   <= '0;
      eval_q <= '0;
      sig_q  <= '0;
      res_q  <= RES_PASS;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state  <= ST_RUN;
            lb_q   <= cfg_mode;
            acc_q  <= cfg_accum;
            len_q  <= cfg_phase_len;
            lat_q  <= cfg_lat;
            ver_q  <= 1'b0;
            eval_q <= ~sig_q & scope;
            dcnt   <= '0;
          end else if (sig_valid) begin
            sig_q <= sig_data;
          end
        end
        ST_RUN: begin
          if (!pg_act) begin
            if (dcnt == lat_q) state <= ST_EVAL;
            else               dcnt  <= dcnt + 1'b1;
          end
        end
        ST_EVAL: begin
          sig_q <= sig_next;
          if (too_many)              res_q <= RES_UNREPAIRABLE;
          else if (fail_vec == '0)   res_q <= RES_PASS;
          else                       res_q <= RES_REPAIRABLE;
          state <= want_wr ? ST_WRITE : ST_DONE;
        end
        ST_WRITE: begin
          if (rep_ready) begin
            state  <= ST_RUN;
            ver_q  <= 1'b1;
            eval_q <= inuse;
            dcnt   <= '0;
          end
        end
        ST_DONE:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign lb_sel    = lb_q;
  assign tx_pat    = pg_pat;
  assign rep_valid = (state == ST_WRITE);
  assign rep_data  = sig_q;
  assign sig_ready = (state == ST_IDLE) && !start;
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_DONE);
  assign result    = res_q;

endmodule

// File: rtl/d2d_lane_bist_chk.sv
module d2d_lane_bist_chk #(
  parameter int NL     = 10,
  parameter int SPARES = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic [1:0]    result,
  input logic          rep_valid,
  input logic          rep_ready,
  input logic [NL-1:0] rep_data,
  input logic          sig_ready,
  input logic [NL-1:0] tx_pat,
  input logic [1:0]    lb_sel
);
  AST_LB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(lb_sel)); // R1

  AST_TX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (tx_pat == '0)); // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

  AST_RESULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result != 2'b11)); // R6

  AST_REP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_valid && !rep_ready) |=> (rep_valid && $stable(rep_data))); // R8

  AST_REP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid |-> ((rep_data != '0) && ($countones(rep_data) <= SPARES))); // R8

  AST_SIG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    sig_ready |-> !busy); // R10
endmodule

bind d2d_lane_bist d2d_lane_bist_chk #(.NL(NL), .SPARES(SPARES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .result    (result),
  .rep_valid (rep_valid),
  .rep_ready (rep_ready),
  .rep_data  (rep_data),
  .sig_ready (sig_ready),
  .tx_pat    (tx_pat),
  .lb_sel    (lb_sel)
);

// File: tb/tb_d2d_lane_bist.sv
module tb_d2d_lane_bist;
  localparam int LANES = 8;
  localparam int SPARES = 2;
  localparam int NL = LANES + SPARES;
  localparam int CNT_W = 16;
  localparam int MAXL = 7;
  localparam int LW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] cfg_mode = '0;
  logic cfg_spares = 1'b0;
  logic cfg_accum = 1'b0;
  logic [CNT_W-1:0] cfg_phase_len = '0;
  logic [LW-1:0] cfg_lat = '0;
  logic [1:0] lb_sel;
  logic [NL-1:0] tx_pat;
  logic [NL-1:0] rx_dat;
  logic rep_valid;
  logic rep_ready = 1'b0;
  logic [NL-1:0] rep_data;
  logic sig_valid = 1'b0;
  logic sig_ready;
  logic [NL-1:0] sig_data = '0;
  logic busy, done;
  logic [1:0] result;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  d2d_lane_bist #(.LANES(LANES), .SPARES(SPARES), .CNT_W(CNT_W), .MAX_LAT(MAXL)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_mode(cfg_mode), .cfg_spares(cfg_spares),
    .cfg_accum(cfg_accum), .cfg_phase_len(cfg_phase_len), .cfg_lat(cfg_lat), .lb_sel(lb_sel),
    .tx_pat(tx_pat), .rx_dat(rx_dat), .rep_valid(rep_valid), .rep_ready(rep_ready),
    .rep_data(rep_data), .sig_valid(sig_valid), .sig_ready(sig_ready), .sig_data(sig_data),
    .busy(busy), .done(done), .result(result)
  );

  // loopback channel model: delay plus injected defects
  int b_lat = 0;
  logic [NL-1:0] f_s0 = '0, f_s1 = '0, f_br = '0;
  logic [NL-1:0] dl [MAXL];
  logic [NL-1:0] raw, brd;

  always_ff @(posedge clk) begin
    dl[0] <= tx_pat;
    for (int k = 1; k < MAXL; k++) dl[k] <= dl[k-1];
  end

  always_comb begin
    raw = (b_lat == 0) ? tx_pat : dl[(b_lat == 0) ? 0 : b_lat - 1];
    brd = raw;
    for (int i = 0; i < NL - 1; i++)
      if (f_br[i]) begin
        brd[i]   = raw[i] & raw[i+1];
        brd[i+1] = raw[i] & raw[i+1];
      end
    rx_dat = (brd & ~f_s0) | f_s1;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [NL-1:0] exp_pat(input int len, input int n);
    int ph, t;
    logic [NL-1:0] p;
    logic [6:0] s;
    ph = n / len;
    t = n % len;
    for (int i = 0; i < NL; i++) begin
      case (ph)
        0: p[i] = (i == t % NL);
        1: p[i] = (i != t % NL);
        2: p[i] = 1'((i % 2) ^ (t % 2));
        default: begin
          s = 7'(i + 1);
          for (int r = 0; r < t; r++) s = {s[5:0], s[6] ^ s[5]};
          p[i] = s[6];
        end
      endcase
    end
    return p;
  endfunction

  task automatic load_sig(input logic [NL-1:0] v);
    sig_data = v;
    sig_valid = 1'b1;
    @(negedge clk);
    sig_valid = 1'b0;
  endtask

  logic [NL-1:0] first_wd;

  task automatic run_one(input logic [1:0] mode, input logic sp, input logic acc, input int lat,
                         input int len, input logic [NL-1:0] s0, input logic [NL-1:0] s1,
                         input logic [NL-1:0] br, input int stall, input string tag,
                         output logic [1:0] res, output int nwr, output logic [NL-1:0] wd,
                         output logic held_bad);
    int st;
    logic seen_done;
    nwr = 0; wd = '0; st = 0; held_bad = 1'b0; res = 2'b11; seen_done = 1'b0;
    f_s0 = s0; f_s1 = s1; f_br = br; b_lat = lat;
    cfg_mode = mode; cfg_spares = sp; cfg_accum = acc;
    cfg_phase_len = CNT_W'(len); cfg_lat = LW'(lat);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R1", {tag, " lb_sel"}, 32'(lb_sel), 32'(mode));
    chk("R10", {tag, " sig_ready while busy"}, 32'(sig_ready), 32'd0);
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if (done) begin
        res = result;
        seen_done = 1'b1;
        break;
      end
      if (rep_valid) begin
        if (st == 0) first_wd = rep_data;
        else if (rep_data !== first_wd) held_bad = 1'b1;
        if (st < stall) begin
          rep_ready = 1'b0;
          st++;
        end else begin
          rep_ready = 1'b1;
          wd = rep_data;
          nwr++;
          st = 0;
        end
      end else begin
        rep_ready = 1'b0;
        st = 0;
      end
      @(negedge clk);
    end
    rep_ready = 1'b0;
    if (!seen_done) chk("R6", {tag, " done seen"}, 32'd0, 32'd1);
    @(negedge clk);
  endtask

  typedef struct packed {
    logic [1:0]    mode;
    logic          sp;
    logic [2:0]    lat;
    logic [7:0]    len;
    logic [NL-1:0] pre;
    logic [NL-1:0] s0;
    logic [NL-1:0] s1;
    logic [NL-1:0] br;
    logic [1:0]    eres;
    logic          ewr;
    logic [NL-1:0] ewd;
  } vec_t;

  localparam int NV = 11;
  // lanes 0..7 data, 8..9 spare; result 0 pass, 1 repairable, 2 unrepairable
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b0, 3'd0, 8'd4,  10'h000, 10'h000, 10'h000, 10'h000, 2'd0, 1'b0, 10'h000}, // clean link
    '{2'd1, 1'b0, 3'd2, 8'd12, 10'h000, 10'h004, 10'h000, 10'h000, 2'd0, 1'b1, 10'h004}, // open lane 2
    '{2'd2, 1'b0, 3'd3, 8'd10, 10'h000, 10'h000, 10'h000, 10'h010, 2'd0, 1'b1, 10'h030}, // bridge 4-5
    '{2'd3, 1'b0, 3'd1, 8'd5,  10'h000, 10'h000, 10'h0C2, 10'h000, 2'd2, 1'b0, 10'h000}, // three stuck-1
    '{2'd1, 1'b0, 3'd0, 8'd6,  10'h000, 10'h108, 10'h000, 10'h000, 2'd1, 1'b1, 10'h008}, // bad spare found by rerun
    '{2'd1, 1'b1, 3'd5, 8'd6,  10'h000, 10'h108, 10'h000, 10'h000, 2'd0, 1'b1, 10'h108}, // spares pre-tested
    '{2'd0, 1'b0, 3'd4, 8'd4,  10'h000, 10'h200, 10'h000, 10'h000, 2'd0, 1'b0, 10'h000}, // spare fault ignored
    '{2'd2, 1'b1, 3'd7, 8'd3,  10'h000, 10'h000, 10'h001, 10'h000, 2'd0, 1'b1, 10'h001}, // max latency
    '{2'd3, 1'b0, 3'd1, 8'd6,  10'h010, 10'h010, 10'h000, 10'h000, 2'd0, 1'b1, 10'h010}, // known-bad excluded
    '{2'd0, 1'b0, 3'd2, 8'd6,  10'h010, 10'h001, 10'h000, 10'h000, 2'd0, 1'b1, 10'h011}, // known-bad plus new
    '{2'd1, 1'b1, 3'd6, 8'd4,  10'h0C0, 10'h0C2, 10'h000, 10'h000, 2'd2, 1'b0, 10'h000}  // over the spare count
  };

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [1:0] res;
    int nwr;
    logic [NL-1:0] wd;
    logic hb;
    int mism;

    repeat (4) @(negedge clk);
    // R11: reset state
    chk("R11", "busy", 32'(busy), 32'd0);
    chk("R11", "done", 32'(done), 32'd0);
    chk("R11", "rep_valid", 32'(rep_valid), 32'd0);
    chk("R11", "tx_pat", 32'(tx_pat), 32'd0);
    chk("R11", "sig_ready", 32'(sig_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table (R1 R3 R4 R5 R6 R8 R9 R10)
    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = $sformatf("vec%0d", v);
      load_sig(VEC[v].pre);
      run_one(VEC[v].mode, VEC[v].sp, 1'b0, int'(VEC[v].lat), int'(VEC[v].len),
              VEC[v].s0, VEC[v].s1, VEC[v].br, v % 3, tag, res, nwr, wd, hb);
      chk("R6", {tag, " result"}, 32'(res), 32'(VEC[v].eres));
      chk("R8", {tag, " write count"}, 32'(nwr), VEC[v].ewr ? 32'd1 : 32'd0);
      if (VEC[v].ewr) chk("R9", {tag, " written signature"}, 32'(wd), 32'(VEC[v].ewd));
      chk("R8", {tag, " data held under stall"}, 32'(hb), 32'd0);
    end

    // R2: pattern sequence, then quiet lanes
    load_sig('0);
    f_s0 = '0; f_s1 = '0; f_br = '0; b_lat = 0;
    cfg_mode = 2'd0; cfg_spares = 1'b0; cfg_accum = 1'b1;
    cfg_phase_len = 16'd3; cfg_lat = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    mism = 0;
    for (int n = 0; n < 12; n++) begin
      if (tx_pat !== exp_pat(3, n)) mism++;
      @(negedge clk);
    end
    chk("R2", "pattern mismatched cycles", 32'(mism), 32'd0);
    chk("R2", "tx_pat after last phase", 32'(tx_pat), 32'd0);
    while (!done) @(negedge clk);
    @(negedge clk);

    // R2: zero phase length behaves as one cycle per phase
    cfg_phase_len = 16'd0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    mism = 0;
    for (int n = 0; n < 4; n++) begin
      if (tx_pat !== exp_pat(1, n)) mism++;
      @(negedge clk);
    end
    chk("R2", "len0 pattern mismatched cycles", 32'(mism), 32'd0);
    chk("R2", "len0 tx_pat after last phase", 32'(tx_pat), 32'd0);
    while (!done) @(negedge clk);
    @(negedge clk);

    // R7: merge across corner runs, then commit
    load_sig('0);
    run_one(2'd3, 1'b0, 1'b1, 2, 6, 10'h004, '0, '0, 0, "acc1", res, nwr, wd, hb);
    chk("R7", "acc1 result", 32'(res), 32'd1);
    chk("R7", "acc1 no write", 32'(nwr), 32'd0);
    run_one(2'd3, 1'b0, 1'b1, 2, 6, 10'h020, '0, '0, 0, "acc2", res, nwr, wd, hb);
    chk("R7", "acc2 result", 32'(res), 32'd1);
    chk("R7", "acc2 no write", 32'(nwr), 32'd0);
    run_one(2'd3, 1'b0, 1'b0, 2, 6, '0, '0, '0, 5, "acc3", res, nwr, wd, hb);
    chk("R7", "acc3 result", 32'(res), 32'd0);
    chk("R7", "acc3 one write", 32'(nwr), 32'd1);
    chk("R7", "acc3 merged signature", 32'(wd), 32'h024);
    chk("R8", "acc3 held under long stall", 32'(hb), 32'd0);

    // R3: latency off by one cycle exposes the compare alignment
    load_sig('0);
    f_s0 = '0; f_s1 = '0; f_br = '0;
    run_one(2'd1, 1'b1, 1'b1, 3, 5, '0, '0, '0, 0, "latok", res, nwr, wd, hb);
    chk("R3", "matched latency passes", 32'(res), 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule